// File: doc/BRIEF.md
# Camera Byte Bus to Video Stream Decoder

This block sits right after a parallel CMOS image sensor. The sensor delivers each RGB565 pixel as two consecutive bytes on an 8-bit bus while its line-active strobe is high. The block rebuilds each 16-bit pixel and widens every colour channel to eight bits, with the added low bits set to zero. The result goes out as a 32-bit AXI4-Stream beat. A downstream video DMA uses the one-cycle frame-sync pulse to lock onto frame boundaries. It uses `tlast` to find line ends, and `tuser` to mark the first pixel of a frame.

The decoder runs in the sensor's pixel clock domain (about 25 MHz) at the sensor's own pace, nominally 30 frames per second. It has no buffer and no flow control. Each beat is presented for exactly one cycle, whatever the consumer reports on `tready`. Nothing is held back or repeated.

The active window is `ACTIVE_W` by `ACTIVE_H` pixels, 640 by 480 by default. Pixels that fall outside this window are discarded. So are pixels that arrive before the first frame start seen after reset.

Top module: `cam_stream_decoder`

## Requirements
- R1: While reset is asserted, and in the first cycles after it is released, `tvalid`, `tlast`, `tuser` and `frameSync` are all low.
- R2: Every two consecutive bytes taken while `camHref` is high form one pixel, and the first byte is the upper half of the RGB565 word. Each pixel gives exactly one `tvalid` cycle, in the clock cycle after the edge that samples its second byte. Two `tvalid` cycles are never adjacent.
- R3: The RGB565 word packs red in bits 15:11, green in bits 10:5 and blue in bits 4:0. On a valid beat, `tdata` is {8'h00, red, 3'b000, green, 2'b00, blue, 3'b000}.
- R4: After the clock edge that first samples `camVsync` low following a high, `frameSync` is high for exactly one cycle.
- R5: `tuser` is high on the first emitted pixel after each frame start, and on no other beat.
- R6: `tlast` is high on the `ACTIVE_W`-th pixel of a line, together with `tvalid`. Any further pixels in that line produce no beat.
- R7: A line that produced at least one pixel advances the line count when `camHref` falls. After `ACTIVE_H` such lines, no more beats are produced until the next frame start.
- R8: `tready` has no effect. The beat sequence is identical whether or not the consumer is ready, and a beat offered while `tready` is low is not offered again.
- R9: If `camHref` falls after an odd number of bytes, the byte pairing restarts. The leftover byte is discarded, and the next line's first byte is again treated as an upper half.
- R10: Pixels that arrive after reset but before the first frame start produce no beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pixClk | input | 1 | Sensor pixel clock; all logic is on its rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| camVsync | input | 1 | Sensor frame strobe; its falling edge starts a frame |
| camHref | input | 1 | Sensor line-active strobe; bytes are taken while high |
| camData | input | 8 | Sensor data byte |
| tready | input | 1 | Consumer ready; ignored |
| tdata | output | 32 | Zero-padded RGB888 pixel |
| tvalid | output | 1 | One-cycle beat strobe per pixel |
| tlast | output | 1 | Last pixel of an active line |
| tuser | output | 1 | First pixel of a frame |
| frameSync | output | 1 | One-cycle pulse at frame start |

## Verification
A byte-phase flip shows at the ports on the very next pixel. Upper and lower halves swap, so the colour fields in `tdata` are scrambled, or a beat appears one byte early. A column or line counter that goes wrong moves or drops the `tlast` flag within one line. It can also let beats through past the window, or hold them back within one frame. A stuck first-of-frame flag puts `tuser` on the wrong beat at the next frame start. The bench therefore compares every beat, in order, against a queue built from the byte stimulus. It also treats any beat that arrives when the queue is empty as an error.

// File: rtl/cam_stream_pkg.sv
package cam_stream_pkg;

  // Per-cycle commands from the control path to the datapath.
  typedef struct packed {
    logic takeHigh;    // current byte is the upper half of a pixel
    logic emit;        // current byte completes an in-window pixel
    logic lastPixel;   // that pixel closes the active line
    logic firstPixel;  // that pixel opens the frame
    logic frameSync;   // frame start detected this cycle
  } camStrobe_t;

endpackage

// File: rtl/cam_stream_ctrl.sv
module cam_stream_ctrl
  import cam_stream_pkg::*;
#(
  parameter int ACTIVE_W = 640,
  parameter int ACTIVE_H = 480
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       vsync,
  input  logic       href,
  output camStrobe_t strobe
);

  localparam int COL_W = $clog2(ACTIVE_W + 1);
  localparam int ROW_W = $clog2(ACTIVE_H + 1);
  localparam logic [COL_W-1:0] COL_END  = COL_W'(ACTIVE_W);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(ACTIVE_W - 1);
  localparam logic [ROW_W-1:0] ROW_END  = ROW_W'(ACTIVE_H);

  logic             phase;
  logic             vsyncPrev;
  logic             hrefPrev;
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;
  logic             inFrame;
  logic             headPending;

  logic vsyncFall;
  logic lineDone;
  logic inWindow;

  always_comb begin
    vsyncFall         = vsyncPrev & ~vsync;
    lineDone          = hrefPrev & ~href;
    inWindow          = inFrame && (col < COL_END) && (row < ROW_END);
    strobe.takeHigh   = href & ~phase;
    strobe.emit       = href & phase & inWindow & ~vsyncFall;
    strobe.lastPixel  = strobe.emit && (col == COL_LAST);
    strobe.firstPixel = strobe.emit && headPending;
    strobe.frameSync  = vsyncFall;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase       <= 1'b0;
      vsyncPrev   <= 1'b0;
      hrefPrev    <= 1'b0;
      col         <= '0;
      row         <= '0;
      inFrame     <= 1'b0;
      headPending <= 1'b0;
    end else begin
      vsyncPrev <= vsync;
      hrefPrev  <= href;
      if (vsyncFall) begin
        phase       <= 1'b0;
        col         <= '0;
        row         <= '0;
        inFrame     <= 1'b1;
        headPending <= 1'b1;
      end else begin
        phase <= href ? ~phase : 1'b0;
        if (strobe.emit) begin
          col         <= col + 1'b1;
          headPending <= 1'b0;
        end
        if (lineDone && col != '0) begin
          col <= '0;
          if (row < ROW_END) row <= row + 1'b1;
        end
      end
    end
  end

  // R6: column count never passes the window width
  a_r6_col_bound : assert property (@(posedge clk) disable iff (!rstN)
    col <= COL_END);

  // R7: line count never passes the window height
  a_r7_row_bound : assert property (@(posedge clk) disable iff (!rstN)
    row <= ROW_END);

  // R9: a low line strobe clears the byte pairing
  a_r9_phase_clear : assert property (@(posedge clk) disable iff (!rstN)
    !href |=> !phase);

  // R10: nothing is emitted before a frame has started
  a_r10_no_early : assert property (@(posedge clk) disable iff (!rstN)
    strobe.emit |-> inFrame);

endmodule

// File: rtl/cam_stream_datapath.sv
module cam_stream_datapath
  import cam_stream_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  dataIn,
  input  camStrobe_t  strobe,
  output logic [31:0] tdata,
  output logic        tvalid,
  output logic        tlast,
  output logic        tuser,
  output logic        frameSync
);

  logic [7:0]  highByte;
  logic [15:0] pix565;
  logic [31:0] pix888;

  always_comb begin
    pix565 = {highByte, dataIn};
    pix888 = {8'h00, pix565[15:11], 3'b000, pix565[10:5], 2'b00,
              pix565[4:0], 3'b000};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      highByte  <= '0;
      tdata     <= '0;
      tvalid    <= 1'b0;
      tlast     <= 1'b0;
      tuser     <= 1'b0;
      frameSync <= 1'b0;
    end else begin
      if (strobe.takeHigh) highByte <= dataIn;
      if (strobe.emit) tdata <= pix888;
      tvalid    <= strobe.emit;
      tlast     <= strobe.lastPixel;
      tuser     <= strobe.firstPixel;
      frameSync <= strobe.frameSync;
    end
  end

  // R2: a pixel needs two bytes, so beats are never adjacent
  a_r2_beat_gap : assert property (@(posedge clk) disable iff (!rstN)
    tvalid |=> !tvalid);

  // R6: end-of-line marker only rides on a beat
  a_r6_last_on_beat : assert property (@(posedge clk) disable iff (!rstN)
    tlast |-> tvalid);

  // R5: frame-start marker only rides on a beat
  a_r5_user_on_beat : assert property (@(posedge clk) disable iff (!rstN)
    tuser |-> tvalid);

  // R4: frame-sync pulse lasts one cycle
  a_r4_sync_single : assert property (@(posedge clk) disable iff (!rstN)
    frameSync |=> !frameSync);

endmodule

// File: rtl/cam_stream_decoder.sv
module cam_stream_decoder
  import cam_stream_pkg::*;
#(
  parameter int ACTIVE_W = 640,
  parameter int ACTIVE_H = 480
) (
  input  logic        pixClk,
  input  logic        rstN,
  input  logic        camVsync,
  input  logic        camHref,
  input  logic [7:0]  camData,
  input  logic        tready,
  output logic [31:0] tdata,
  output logic        tvalid,
  output logic        tlast,
  output logic        tuser,
  output logic        frameSync
);

  camStrobe_t strobe;
  logic       droppedBeat;

  cam_stream_ctrl #(
    .ACTIVE_W(ACTIVE_W),
    .ACTIVE_H(ACTIVE_H)
  ) u_ctrl (
    .clk   (pixClk),
    .rstN  (rstN),
    .vsync (camVsync),
    .href  (camHref),
    .strobe(strobe)
  );

  cam_stream_datapath u_data (
    .clk      (pixClk),
    .rstN     (rstN),
    .dataIn   (camData),
    .strobe   (strobe),
    .tdata    (tdata),
    .tvalid   (tvalid),
    .tlast    (tlast),
    .tuser    (tuser),
    .frameSync(frameSync)
  );

  assign droppedBeat = tvalid & ~tready;

  // R8: a beat refused by the consumer is not offered again
  a_r8_no_retry : assert property (@(posedge pixClk) disable iff (!rstN)
    droppedBeat |=> !tvalid);

endmodule

// File: tb/test_cam_stream_decoder.sv
`timescale 1ns/1ps
module test_cam_stream_decoder;

  localparam int W = 4;
  localparam int H = 2;

  logic        pixClk = 1'b0;
  logic        rstN = 1'b0;
  logic        camVsync = 1'b0;
  logic        camHref = 1'b0;
  logic [7:0]  camData = 8'h00;
  logic        tready = 1'b1;
  logic [31:0] tdata;
  logic        tvalid;
  logic        tlast;
  logic        tuser;
  logic        frameSync;

  int checks = 0;
  int fails = 0;
  int expBeats = 0;
  int gotBeats = 0;

  logic [33:0] expQ[$];

  int mCol = 0;
  int mRow = 0;
  bit mInFrame = 0;
  bit mHead = 0;

  cam_stream_decoder #(.ACTIVE_W(W), .ACTIVE_H(H)) i_cam_stream_decoder (
    .pixClk(pixClk), .rstN(rstN), .camVsync(camVsync), .camHref(camHref),
    .camData(camData), .tready(tready), .tdata(tdata), .tvalid(tvalid),
    .tlast(tlast), .tuser(tuser), .frameSync(frameSync)
  );

  always #2 pixClk = ~pixClk;

  task automatic chk(input bit ok, input string tag,
                     input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] widen(input logic [15:0] p);
    return {8'h00, p[15:11], 3'b000, p[10:5], 2'b00, p[4:0], 3'b000};
  endfunction

  task automatic sendPixel(input logic [15:0] px);
    camHref = 1'b1;
    camData = px[15:8];
    @(negedge pixClk);
    camData = px[7:0];
    if (mInFrame && mCol < W && mRow < H) begin
      expQ.push_back({mHead, (mCol == W - 1), widen(px)});
      expBeats++;
      mHead = 0;
      mCol++;
    end
    @(negedge pixClk);
  endtask

  task automatic endLine();
    camHref = 1'b0;
    camData = 8'h00;
    if (mCol > 0) begin
      if (mRow < H) mRow++;
      mCol = 0;
    end
    repeat (3) @(negedge pixClk);
  endtask

  task automatic sendLine(input int n, input logic [15:0] seed);
    for (int i = 0; i < n; i++) sendPixel(seed ^ 16'(i * 16'h1357));
    endLine();
  endtask

  task automatic frameStart();
    camVsync = 1'b1;
    repeat (2) @(negedge pixClk);
    camVsync = 1'b0;
    mCol = 0;
    mRow = 0;
    mInFrame = 1;
    mHead = 1;
    @(negedge pixClk);
    chk(frameSync === 1'b1, "R4 sync high", 36'(frameSync), 36'd1);
    @(negedge pixClk);
    chk(frameSync === 1'b0, "R4 sync one cycle", 36'(frameSync), 36'd0);
  endtask

  // Monitor: compare every beat with the scoreboard queue (R2 R3 R5 R6 R7 R10)
  initial begin
    forever begin
      @(negedge pixClk);
      if (rstN && tvalid === 1'b1) begin
        gotBeats++;
        if (expQ.size() == 0) begin
          chk(1'b0, "R10/R7 unexpected beat", {2'b0, tuser, tlast, tdata}, 36'd0);
        end else begin
          logic [33:0] e;
          e = expQ.pop_front();
          chk(tdata === e[31:0], "R3 R2 pixel data", 36'(tdata), 36'(e[31:0]));
          chk(tlast === e[32], "R6 line end", 36'(tlast), 36'(e[32]));
          chk(tuser === e[33], "R5 frame head", 36'(tuser), 36'(e[33]));
        end
      end
    end
  end

  // R8: consumer readiness toggles in an irregular pattern throughout
  initial begin
    forever begin
      repeat (3) @(negedge pixClk);
      tready = ~tready;
      repeat (5) @(negedge pixClk);
      tready = ~tready;
    end
  end

  initial begin
    repeat (50000) @(posedge pixClk);
    chk(1'b0, "watchdog", 36'd0, 36'd1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge pixClk);
    chk({tvalid, tlast, tuser, frameSync} === 4'b0, "R1 in reset",
        36'({tvalid, tlast, tuser, frameSync}), 36'd0);
    rstN = 1'b1;
    @(negedge pixClk);
    chk({tvalid, tlast, tuser, frameSync} === 4'b0, "R1 after reset",
        36'({tvalid, tlast, tuser, frameSync}), 36'd0);

    // R10: a line before any frame start yields nothing
    sendLine(3, 16'hABCD);

    // Frame 1: exact line, overlong line (R6), extra line past H (R7)
    frameStart();
    sendLine(W, 16'hF800);
    sendLine(W + 2, 16'h07E0);
    sendLine(W, 16'h001F);

    // Frame 2: odd stray byte (R9), then full line, short line, extra
    frameStart();
    camHref = 1'b1;
    camData = 8'h5A;
    @(negedge pixClk);
    endLine();
    sendLine(W, 16'h1234);
    sendLine(2, 16'hFFFF);
    sendLine(W, 16'h8421);

    // Frame 3: white and black boundary values
    frameStart();
    sendPixel(16'hFFFF);
    sendPixel(16'h0000);
    endLine();

    repeat (6) @(negedge pixClk);
    chk(expQ.size() == 0, "R8 R2 all expected beats seen",
        36'(expQ.size()), 36'd0);
    chk(gotBeats == expBeats, "R8 beat count", 36'(gotBeats), 36'(expBeats));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule